// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This block watches the instruction fetch bus and the execute stage of a CPU with 16-bit instructions whose bus delivers one 32-bit word, that is two instructions, per fetch. It holds a set of breakpoint channels. Each channel has a halfword instruction address and a timing choice: the trap is taken either before or after the matching instruction runs. A fetch only arms a match. The trap request is raised when the pipeline confirms that the armed instruction is really going to execute. Overrun fetches thrown away by a branch or an exception therefore never trap.

Armed matches are held in a small tag table, one entry per fetched instruction that hit at least one channel. The execute stage presents one unit per cycle. A unit is either a single instruction or a delayed branch together with its delay slot, the slot sitting at the next halfword. The table is searched for both instructions of the unit. A pipeline flush or an exception clears every armed entry, so an instruction that was hit by an exception traps only after it has been fetched again. When several channels hit at the same boundary, one request pulse is raised and a per-channel flag vector records which channels caused it.

Top module: `ifetch_break_unit`

## Requirements
- R1: A channel whose enable bit is 0 never causes a trap. An enabled channel matches an instruction only when its halfword address equals the instruction's halfword address exactly. A neighbouring halfword does not match.
- R2: Fetch word address W carries two instructions: halfword {W,0}, the first in program order, and halfword {W,1}. Both are armed from the one fetch, so channel A can match one of them and channel B the other, and each traps when its own instruction executes.
- R3: A trap happens only for an instruction that was armed by a fetch in an earlier cycle and is then presented on the execute port. An instruction that is never fetched, or that is fetched in the same cycle it is presented, does not trap. Raising the flush input discards every armed entry from before that cycle.
- R4: A unit presented with the exception flag never traps. It also discards all armed entries, so the same instruction traps only once it has been fetched again and re-executed.
- R5: With the delayed-branch flag set, the unit is the branch at the given halfword plus its slot at the next halfword. A before-execution match on either of them traps with brk_pre = 1, that is, before the branch executes.
- R6: When the unit is a return-from-exception delayed branch (exe_rte and exe_dbr both 1), a before-execution match on its delay slot is suppressed. A before-execution match on the branch itself still traps.
- R7: A channel with its post bit set traps with brk_pre = 0 after the whole unit has executed. For a delayed branch this is after the delay slot and before the branch target.
- R8: If the same unit has both before-execution and after-execution hits, only the before-execution trap is reported. brk_chan then lists only the before-execution channels.
- R9: Hits on several channels at the same boundary give one request pulse. brk_chan then has bit c set for every channel c that caused it (bit 0 is channel A, bit 1 is channel B).
- R10: brk_req is a one-cycle pulse in the cycle after the unit is presented. brk_pre and brk_chan change only together with a pulse and hold their values otherwise. After reset all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | N_CH | Per-channel enable for instruction-fetch breaks |
| ch_post | input | N_CH | Per-channel timing: 1 = after execution, 0 = before |
| ch_ha | input | N_CH*(ADDR_W-1) | Per-channel halfword address, channel c in slice c |
| fetch_valid | input | 1 | A 32-bit fetch completes this cycle |
| fetch_wa | input | ADDR_W-2 | Word address of the fetch |
| exe_valid | input | 1 | An execution unit is presented this cycle |
| exe_ha | input | ADDR_W-1 | Halfword address of the unit's first instruction |
| exe_dbr | input | 1 | Unit is a delayed branch plus its delay slot |
| exe_rte | input | 1 | Delayed branch is a return from exception |
| exe_exc | input | 1 | Unit takes an exception instead of executing |
| pipe_flush | input | 1 | Overrun fetches are squashed |
| brk_req | output | 1 | Trap request pulse |
| brk_pre | output | 1 | 1 = trap before the unit, 0 = after it |
| brk_chan | output | N_CH | Channels that caused the latest trap |

## Verification
The bench builds the block with ADDR_W = 12, two channels and a four-entry tag table. The narrow addresses keep every halfword pattern easy to write down. The small table is the smallest one that still holds both halves of a fetch with room to spare. With this setup the bench can sweep every combination of timing bits against both half positions of a fetch, and every placement of two channels on a delayed-branch unit with and without the return marker. It then covers the squash, exception, same-cycle and disabled-channel cases one at a time.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

   // Position of an instruction inside a 32-bit fetch word
   typedef enum logic {
      HALF_FIRST  = 1'b0,
      HALF_SECOND = 1'b1
   } half_pos_e;

   // Outcome of evaluating one execution unit
   typedef enum logic [1:0] {
      FIRE_NONE = 2'd0,
      FIRE_PRE  = 2'd1,
      FIRE_POST = 2'd2
   } fire_kind_e;

   localparam int unsigned HALVES_PER_FETCH = 2;

endpackage

// File: rtl/ifb_fetch_match.sv
module ifb_fetch_match
   import ifb_pkg::*;
#(
   parameter int unsigned HA_W = 31,
   parameter int unsigned N_CH = 2
) (
   input  logic                 fetch_valid,
   input  logic [HA_W-2:0]      fetch_wa,
   input  logic [N_CH-1:0]      ch_en,
   input  logic [N_CH*HA_W-1:0] ch_ha,
   output logic [HALVES_PER_FETCH-1:0][N_CH-1:0] half_hit
);

   localparam int unsigned WA_W = HA_W - 1;

   // One comparator per (half, channel) pair
   for (genvar h = 0; h < HALVES_PER_FETCH; h++) begin : g_half
      logic [HA_W-1:0] instr_ha;
      assign instr_ha = {fetch_wa[WA_W-1:0], 1'(h)};
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign half_hit[h][c] = fetch_valid & ch_en[c]
                               & (ch_ha[c*HA_W +: HA_W] == instr_ha);
      end
   end

endmodule

// File: rtl/ifb_tag_table.sv
module ifb_tag_table
   import ifb_pkg::*;
#(
   parameter int unsigned HA_W  = 31,
   parameter int unsigned N_CH  = 2,
   parameter int unsigned DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [HALVES_PER_FETCH-1:0][N_CH-1:0] push_hit,
   input  logic [HA_W-2:0]       push_wa,
   input  logic                  q_valid,
   input  logic [HA_W-1:0]       q0_ha,
   input  logic                  q1_en,
   output logic [N_CH-1:0]       q0_hit,
   output logic [N_CH-1:0]       q1_hit
);

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]  ent_v;
   logic [HA_W-1:0]   ent_ha  [DEPTH];
   logic [N_CH-1:0]   ent_hit [DEPTH];

   logic [DEPTH-1:0]  m0, m1, consume;
   logic [HA_W-1:0]   q1_ha;
   logic [HALVES_PER_FETCH-1:0] push;
   logic [IDX_W-1:0]  f0, f1, slot1;
   logic              f0_ok, f1_ok, ok1;

   assign q1_ha = q0_ha + HA_W'(1);

   for (genvar h = 0; h < HALVES_PER_FETCH; h++) begin : g_push
      assign push[h] = |push_hit[h];
   end

   // Associative lookup of both instructions of the unit
   always_comb begin
      q0_hit = '0;
      q1_hit = '0;
      for (int i = 0; i < DEPTH; i++) begin
         m0[i] = q_valid & ent_v[i] & (ent_ha[i] == q0_ha);
         m1[i] = q_valid & q1_en & ent_v[i] & (ent_ha[i] == q1_ha);
         if (m0[i]) q0_hit = q0_hit | ent_hit[i];
         if (m1[i]) q1_hit = q1_hit | ent_hit[i];
      end
      consume = m0 | m1;
   end

   // First two free slots
   always_comb begin
      f0    = '0;
      f1    = '0;
      f0_ok = 1'b0;
      f1_ok = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!ent_v[i]) begin
            if (!f0_ok) begin
               f0    = IDX_W'(i);
               f0_ok = 1'b1;
            end else if (!f1_ok) begin
               f1    = IDX_W'(i);
               f1_ok = 1'b1;
            end
         end
      end
      slot1 = push[HALF_FIRST] ? f1 : f0;
      ok1   = push[HALF_FIRST] ? f1_ok : f0_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_v <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_ha[i]  <= '0;
            ent_hit[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (flush || consume[i]) ent_v[i] <= 1'b0;
         end
         if (push[HALF_FIRST] && f0_ok) begin
            ent_v[f0]   <= 1'b1;
            ent_ha[f0]  <= {push_wa, HALF_FIRST};
            ent_hit[f0] <= push_hit[HALF_FIRST];
         end
         if (push[HALF_SECOND] && ok1) begin
            ent_v[slot1]   <= 1'b1;
            ent_ha[slot1]  <= {push_wa, HALF_SECOND};
            ent_hit[slot1] <= push_hit[HALF_SECOND];
         end
      end
   end

   // A fetch must always find room for every half it arms
   assert_no_overflow_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (push != '0) |-> ((!push[HALF_FIRST] || f0_ok) && (!push[HALF_SECOND] || ok1)));

   // A flush with no new fetch leaves the table empty
   assert_flush_empties_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (flush && (push == '0)) |=> (ent_v == '0));

   // An entry found by the lookup is gone in the next cycle unless refilled by a fetch
   assert_consume_once_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ((consume != '0) && (push == '0)) |=> (($countones(ent_v) < $countones($past(ent_v)))));

endmodule

// File: rtl/ifb_fire.sv
module ifb_fire
   import ifb_pkg::*;
#(
   parameter int unsigned N_CH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exe_valid,
   input  logic            exe_exc,
   input  logic            exe_dbr,
   input  logic            exe_rte,
   input  logic [N_CH-1:0] hit0,
   input  logic [N_CH-1:0] hit1,
   input  logic [N_CH-1:0] ch_post,
   output logic            brk_req,
   output logic            brk_pre,
   output logic [N_CH-1:0] brk_chan
);

   logic [N_CH-1:0] pre_hits, post_hits, slot_pre;
   logic            slot_ok;
   fire_kind_e      kind;

   // Delay-slot before-execution hits are dropped for a return from exception
   assign slot_ok  = ~(exe_dbr & exe_rte);
   assign slot_pre = hit1 & ~ch_post & {N_CH{slot_ok}};
   assign pre_hits  = (hit0 & ~ch_post) | slot_pre;
   assign post_hits = (hit0 | hit1) & ch_post;

   always_comb begin
      kind = FIRE_NONE;
      if (exe_valid && !exe_exc) begin
         if (pre_hits != '0)       kind = FIRE_PRE;
         else if (post_hits != '0) kind = FIRE_POST;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brk_req  <= 1'b0;
         brk_pre  <= 1'b0;
         brk_chan <= '0;
      end else begin
         brk_req <= (kind != FIRE_NONE);
         if (kind == FIRE_PRE) begin
            brk_pre  <= 1'b1;
            brk_chan <= pre_hits;
         end else if (kind == FIRE_POST) begin
            brk_pre  <= 1'b0;
            brk_chan <= post_hits;
         end
      end
   end

   // A request always follows a presented unit that took no exception
   assert_req_follows_unit_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> $past(exe_valid && !exe_exc));

   assert_exc_silent_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (exe_valid && exe_exc) |=> !brk_req);

   // Every request names at least one channel
   assert_chan_named_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> (brk_chan != '0));

   assert_status_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !brk_req |-> ($stable(brk_chan) && $stable(brk_pre)));

   // A before-trap on a return-from-exception unit must come from the branch itself
   assert_rte_slot_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && brk_pre && $past(exe_rte && exe_dbr)) |->
         ($past(hit0 & ~ch_post) != '0));

endmodule

// File: rtl/ifetch_break_unit.sv
module ifetch_break_unit
   import ifb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned N_CH      = 2,
   parameter int unsigned TAG_DEPTH = 4,
   localparam int unsigned HA_W     = ADDR_W - 1,
   localparam int unsigned WA_W     = ADDR_W - 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_CH-1:0]      ch_en,
   input  logic [N_CH-1:0]      ch_post,
   input  logic [N_CH*HA_W-1:0] ch_ha,
   input  logic                 fetch_valid,
   input  logic [WA_W-1:0]      fetch_wa,
   input  logic                 exe_valid,
   input  logic [HA_W-1:0]      exe_ha,
   input  logic                 exe_dbr,
   input  logic                 exe_rte,
   input  logic                 exe_exc,
   input  logic                 pipe_flush,
   output logic                 brk_req,
   output logic                 brk_pre,
   output logic [N_CH-1:0]      brk_chan
);

   // Elaboration-time parameter checks
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ifetch_break_unit: ADDR_W must be at least 4");
   end
   if (N_CH < 1 || N_CH > 2) begin : g_bad_ch
      $error("ifetch_break_unit: N_CH must be 1 or 2");
   end
   if (TAG_DEPTH < HALVES_PER_FETCH) begin : g_bad_depth
      $error("ifetch_break_unit: TAG_DEPTH must hold one full fetch");
   end

   logic [HALVES_PER_FETCH-1:0][N_CH-1:0] half_hit;
   logic [N_CH-1:0] hit0, hit1;
   logic            tbl_flush;

   // Exceptions discard armed fetches just as a squash does
   assign tbl_flush = pipe_flush | (exe_valid & exe_exc);

   ifb_fetch_match #(
      .HA_W (HA_W),
      .N_CH (N_CH)
   ) i_match (
      .fetch_valid (fetch_valid),
      .fetch_wa    (fetch_wa),
      .ch_en       (ch_en),
      .ch_ha       (ch_ha),
      .half_hit    (half_hit)
   );

   ifb_tag_table #(
      .HA_W  (HA_W),
      .N_CH  (N_CH),
      .DEPTH (TAG_DEPTH)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (tbl_flush),
      .push_hit (half_hit),
      .push_wa  (fetch_wa),
      .q_valid  (exe_valid),
      .q0_ha    (exe_ha),
      .q1_en    (exe_dbr),
      .q0_hit   (hit0),
      .q1_hit   (hit1)
   );

   ifb_fire #(
      .N_CH (N_CH)
   ) i_fire (
      .clk       (clk),
      .rst_n     (rst_n),
      .exe_valid (exe_valid),
      .exe_exc   (exe_exc),
      .exe_dbr   (exe_dbr),
      .exe_rte   (exe_rte),
      .hit0      (hit0),
      .hit1      (hit1),
      .ch_post   (ch_post),
      .brk_req   (brk_req),
      .brk_pre   (brk_pre),
      .brk_chan  (brk_chan)
   );

   // Disabled channels never appear in a request
   assert_disabled_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> ((brk_chan & ~$past(ch_en)) == '0));

endmodule

// File: tb/test_ifetch_break_unit.sv
module test_ifetch_break_unit;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned N_CH   = 2;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned HA_W   = ADDR_W - 1;
   localparam int unsigned WA_W   = ADDR_W - 2;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic [N_CH-1:0]      ch_en;
   logic [N_CH-1:0]      ch_post;
   logic [N_CH*HA_W-1:0] ch_ha;
   logic                 fetch_valid;
   logic [WA_W-1:0]      fetch_wa;
   logic                 exe_valid;
   logic [HA_W-1:0]      exe_ha;
   logic                 exe_dbr, exe_rte, exe_exc, pipe_flush;
   logic                 brk_req, brk_pre;
   logic [N_CH-1:0]      brk_chan;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ifetch_break_unit #(
      .ADDR_W    (ADDR_W),
      .N_CH      (N_CH),
      .TAG_DEPTH (DEPTH)
   ) i_ifetch_break_unit (
      .clk (clk), .rst_n (rst_n),
      .ch_en (ch_en), .ch_post (ch_post), .ch_ha (ch_ha),
      .fetch_valid (fetch_valid), .fetch_wa (fetch_wa),
      .exe_valid (exe_valid), .exe_ha (exe_ha), .exe_dbr (exe_dbr),
      .exe_rte (exe_rte), .exe_exc (exe_exc), .pipe_flush (pipe_flush),
      .brk_req (brk_req), .brk_pre (brk_pre), .brk_chan (brk_chan)
   );

   task automatic set_cfg(input logic [1:0] en, input logic [1:0] post,
                          input logic [HA_W-1:0] a, input logic [HA_W-1:0] b);
      ch_en   = en;
      ch_post = post;
      ch_ha   = {b, a};
   endtask

   task automatic fetch_word(input logic [WA_W-1:0] wa);
      fetch_valid = 1'b1;
      fetch_wa    = wa;
      @(posedge clk);
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic run_unit(input logic [HA_W-1:0] ha, input logic dbr,
                           input logic rte, input logic exc);
      exe_valid = 1'b1;
      exe_ha    = ha;
      exe_dbr   = dbr;
      exe_rte   = rte;
      exe_exc   = exc;
      @(posedge clk);
      @(negedge clk);
      exe_valid = 1'b0;
      exe_dbr   = 1'b0;
      exe_rte   = 1'b0;
      exe_exc   = 1'b0;
   endtask

   task automatic do_flush();
      pipe_flush = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pipe_flush = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_none(input string req);
      checks++;
      if (brk_req !== 1'b0) begin
         errors++;
         $display("FAIL %s: brk_req actual %b expected 0", req, brk_req);
      end
   endtask

   task automatic expect_brk(input string req, input logic pre, input logic [1:0] ch);
      logic [3:0] act, exp;
      act = {brk_req, brk_pre, brk_chan};
      exp = {1'b1, pre, ch};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {req,pre,chan} actual %b expected %b", req, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      set_cfg(2'b00, 2'b00, '0, '0);
      fetch_valid = 1'b0; fetch_wa = '0;
      exe_valid = 1'b0; exe_ha = '0;
      exe_dbr = 1'b0; exe_rte = 1'b0; exe_exc = 1'b0; pipe_flush = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      checks++;
      if ({brk_req, brk_pre, brk_chan} !== 4'b0000) begin
         errors++;
         $display("FAIL R10: reset outputs actual %b expected 0000",
                  {brk_req, brk_pre, brk_chan});
      end

      // R2 / R7: two channels on the two halves of one fetch, all timing bits
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 4; w++) begin
               logic [WA_W-1:0] wa;
               logic [1:0] post;
               logic [1:0] first_ch, second_ch;
               wa = WA_W'(10'h040 + w);
               post = 2'(p);
               set_cfg(2'b11, post, {wa, 1'(s)}, {wa, ~1'(s)});
               first_ch  = (s == 0) ? 2'b01 : 2'b10;
               second_ch = (s == 0) ? 2'b10 : 2'b01;
               fetch_word(wa);
               run_unit({wa, 1'b0}, 1'b0, 1'b0, 1'b0);
               expect_brk("R2 R7 first half", (post & first_ch) == 2'b00, first_ch);
               run_unit({wa, 1'b1}, 1'b0, 1'b0, 1'b0);
               expect_brk("R2 R7 second half", (post & second_ch) == 2'b00, second_ch);
               idle();
               expect_none("R10 single-cycle pulse");
               do_flush();
            end
         end
      end

      // R5 R6 R7 R8 R9: delayed-branch unit, every placement of both channels
      for (int p = 0; p < 4; p++) begin
         for (int rte = 0; rte < 2; rte++) begin
            for (int oa = 0; oa < 2; oa++) begin
               for (int ob = 0; ob < 2; ob++) begin
                  logic [WA_W-1:0] wa;
                  logic [1:0] post, h0, h1, pre_h, post_h;
                  wa = WA_W'(10'h080);
                  post = 2'(p);
                  set_cfg(2'b11, post, {wa, 1'(oa)}, {wa, 1'(ob)});
                  h0 = {ob == 0, oa == 0};
                  h1 = {ob == 1, oa == 1};
                  pre_h  = (h0 & ~post) | (h1 & ~post & {2{rte == 0}});
                  post_h = (h0 | h1) & post;
                  fetch_word(wa);
                  run_unit({wa, 1'b0}, 1'b1, 1'(rte), 1'b0);
                  if (pre_h != 2'b00)
                     expect_brk("R5 R6 R8 R9 before unit", 1'b1, pre_h);
                  else if (post_h != 2'b00)
                     expect_brk("R7 R9 after unit", 1'b0, post_h);
                  else
                     expect_none("R6 rte slot suppressed");
                  do_flush();
               end
            end
         end
      end

      // R3: squashed fetch never traps
      set_cfg(2'b01, 2'b00, {10'h090, 1'b0}, '0);
      fetch_word(10'h090);
      do_flush();
      run_unit({10'h090, 1'b0}, 1'b0, 1'b0, 1'b0);
      expect_none("R3 squashed fetch");

      // R3: never-fetched instruction never traps, fetched one does
      set_cfg(2'b01, 2'b00, {10'h091, 1'b0}, '0);
      run_unit({10'h091, 1'b0}, 1'b0, 1'b0, 1'b0);
      expect_none("R3 unfetched");
      fetch_word(10'h091);
      run_unit({10'h091, 1'b0}, 1'b0, 1'b0, 1'b0);
      expect_brk("R3 fetched then executed", 1'b1, 2'b01);

      // R3: fetch and execution in the same cycle do not trap
      set_cfg(2'b01, 2'b00, {10'h0C0, 1'b0}, '0);
      fetch_valid = 1'b1;
      fetch_wa    = 10'h0C0;
      run_unit({10'h0C0, 1'b0}, 1'b0, 1'b0, 1'b0);
      fetch_valid = 1'b0;
      expect_none("R3 same-cycle fetch");
      run_unit({10'h0C0, 1'b0}, 1'b0, 1'b0, 1'b0);
      expect_brk("R3 armed one cycle later", 1'b1, 2'b01);

      // R4: exception first, trap only after refetch
      set_cfg(2'b01, 2'b00, {10'h0A0, 1'b1}, '0);
      fetch_word(10'h0A0);
      run_unit({10'h0A0, 1'b1}, 1'b0, 1'b0, 1'b1);
      expect_none("R4 exception unit");
      run_unit({10'h0A0, 1'b1}, 1'b0, 1'b0, 1'b0);
      expect_none("R4 no refetch yet");
      fetch_word(10'h0A0);
      run_unit({10'h0A0, 1'b1}, 1'b0, 1'b0, 1'b0);
      expect_brk("R4 after refetch", 1'b1, 2'b01);

      // R1: disabled channel and neighbouring halfword
      set_cfg(2'b10, 2'b11, {10'h0B0, 1'b0}, {10'h0B1, 1'b1});
      fetch_word(10'h0B0);
      run_unit({10'h0B0, 1'b0}, 1'b0, 1'b0, 1'b0);
      expect_none("R1 disabled channel");
      fetch_word(10'h0B1);
      run_unit({10'h0B1, 1'b0}, 1'b0, 1'b0, 1'b0);
      expect_none("R1 neighbour halfword");
      run_unit({10'h0B1, 1'b1}, 1'b0, 1'b0, 1'b0);
      expect_brk("R1 exact halfword", 1'b0, 2'b10);

      // R10: status held after the pulse
      repeat (3) idle();
      checks++;
      if ({brk_req, brk_pre, brk_chan} !== 4'b0010) begin
         errors++;
         $display("FAIL R10: held status actual %b expected 0010",
                  {brk_req, brk_pre, brk_chan});
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule